// File: doc/BRIEF.md
# Addressed Serial Transceiver with Station-ID Filter

This block is a full-duplex asynchronous serial transceiver for a shared line. Several stations listen on the line and one of them talks. Each frame carries one extra flag bit after the data bits. When the flag is 1 the frame is an address frame, and when it is 0 the frame is a payload frame. A sender first names the station it wants with an address frame, then sends any number of payload frames.

The receiver compares every address frame with the local `station_id`. A match opens the receive path. The matching address frame is delivered and marked as an address, and each following payload frame is then delivered with receive-full raised. Any other address closes the path. Payload frames that arrive while the path is closed are dropped silently and touch no flag. After reset the path is closed.

The transmitter takes a byte and its flag bit through a single-cycle write strobe into a one-entry holding buffer. It reports buffer-empty and transmit-end. Bit timing comes from an external enable pulse at 16 times the bit rate. Software should only switch between one-way and two-way operation when the idle conditions on the status flags hold.

Top module: `mp_uart`

## Requirements
- R1: A frame on `txd` is, in time order: one start bit at 0, eight data bits with the least significant bit first, the flag bit, and one stop bit at 1. Each bit lasts 16 `tick` pulses. The line idles at 1.
- R2: After reset `tdre` and `tend` are both 1. A `tx_wr` clears both on the next clock. `tdre` returns to 1 when the byte moves into the shifter. `tend` returns to 1 when the stop bit ends and the buffer is empty.
- R3: While `tx_en` is 0, no new frame starts. `txd` stays at 1 and a written byte waits in the buffer.
- R4: The receiver counts a start bit only if `rxd` is still 0 at its midpoint. A low pulse shorter than half a bit is ignored, and the next frame is received correctly.
- R5: An address frame (flag 1) whose data equals `station_id` is delivered. It raises `rdrf`, puts the data on `rx_data`, and sets `rx_is_id` to 1.
- R6: Payload frames (flag 0) that follow a matching address are each delivered with `rx_is_id` at 0.
- R7: After an address frame that does not match, and after reset, payload frames are dropped. They raise neither `rdrf`, `oer` nor `fer`, until the next address frame arrives.
- R8: An accepted frame whose stop bit samples as 0 sets `fer` and is not delivered. The receiver waits for the line to return to 1 before it looks for a new start bit.
- R9: An accepted frame that completes while `rdrf` is 1 sets `oer` and leaves `rx_data` unchanged.
- R10: `rd_ack` clears `rdrf`, and `err_clr` clears `oer` and `fer`. `perr` is always 0 because this frame format has no parity bit.
- R11: While `rx_en` is 0, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_byte | input | 8 | Byte to transmit |
| tx_mpb | input | 1 | Flag bit to send with the byte (1 = address) |
| station_id | input | 8 | Local station address |
| rd_ack | input | 1 | Clears receive-full |
| err_clr | input | 1 | Clears overrun and framing error |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tdre | output | 1 | Transmit buffer empty |
| tend | output | 1 | Transmission finished |
| rdrf | output | 1 | Receive-full |
| oer | output | 1 | Overrun |
| fer | output | 1 | Framing error |
| perr | output | 1 | Parity error (always 0) |
| rx_data | output | 8 | Last delivered byte |
| rx_is_id | output | 1 | Delivered byte was an address frame |

## Verification
The hardest internal fault to see is a wrong address-filter state. It shows up only on the next payload frame, about one frame time later, as either a missing `rdrf` or a spurious one. For that reason every address in the sweep is followed directly by a payload frame. A start detector that accepts a glitch also leaves the filter closed, and this shows as a lost payload frame on the following transfer. A transmit shifter fault shows within one bit time, as a wrong level at mid-bit on `txd`.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_BREAK} rx_state_t;
endpackage

// File: rtl/mp_uart_tx.sv
// Transmitter: one-entry buffer plus shifter. Sends start, data (LSB first),
// flag bit and stop bit, each OSR ticks long.
// Assumes tick is a single-cycle pulse and OSR is a power of two.
module mp_uart_tx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          wmpb,
    output logic          txd,
    output logic          tdre,
    output logic          tend
);
    localparam int CW = $clog2(OSR);
    localparam int NB = DW + 3;
    localparam int BW = $clog2(NB);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] FINAL = BW'(NB - 1);

    logic [NB-1:0] sh;
    logic [DW-1:0] buf_data;
    logic          buf_mpb;
    logic          busy;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] bitn;

    // Buffer, shifter and status flags; a write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1; buf_data <= '0; buf_mpb <= 1'b0; busy <= 1'b0;
            tcnt <= '0; bitn <= '0; tdre <= 1'b1; tend <= 1'b1;
        end else begin
            if (busy) begin
                if (tick) begin
                    if (tcnt == LAST) begin
                        tcnt <= '0;
                        if (bitn == FINAL) begin
                            busy <= 1'b0;
                            tend <= tdre;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sh   <= {1'b1, sh[NB-1:1]};
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
            end else if (!tdre && en) begin
                sh   <= {1'b1, buf_mpb, buf_data, 1'b0};
                busy <= 1'b1;
                tdre <= 1'b1;
                tcnt <= '0;
                bitn <= '0;
            end
            if (wr) begin
                buf_data <= wdata;
                buf_mpb  <= wmpb;
                tdre     <= 1'b0;
                tend     <= 1'b0;
            end
        end
    end

    // Line output: shifter LSB while a frame is in flight, idle high otherwise.
    assign txd = busy ? sh[0] : 1'b1;

    a_r2_tend_needs_tdre: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> tdre);
    a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (!tdre && !tend));
    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && txd && !busy) |=> txd);
endmodule

// File: rtl/mp_uart_rx.sv
// Receiver: start detection with mid-bit check, shift in data and flag bit,
// sample stop bit, then update status for frames the filter accepts.
// Assumes rxd is asynchronous (synchronised here) and OSR is a power of two.
module mp_uart_rx
    import mp_uart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    input  logic          rd_ack,
    input  logic          err_clr,
    input  logic          accept,
    output logic          frame_done,
    output logic          frame_mpb,
    output logic [DW-1:0] frame_data,
    output logic          rdrf,
    output logic          oer,
    output logic          fer,
    output logic [DW-1:0] data_q,
    output logic          is_id
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW + 2);
    localparam logic [CW-1:0] MID   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
    localparam logic [BW-1:0] STOPB = BW'(DW + 1);

    rx_state_t     st;
    logic [1:0]    sy;
    logic          rxs;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] bitn;
    logic [DW:0]   sh;

    // Two-stage synchroniser for the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sy <= 2'b11;
        else        sy <= {sy[0], rxd};
    end
    assign rxs = sy[1];

    // Bit-timing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RX_IDLE; tcnt <= '0; bitn <= '0; sh <= '0;
        end else if (!en) begin
            st <= RX_IDLE;
        end else if (tick) begin
            case (st)
                RX_IDLE: if (!rxs) begin st <= RX_START; tcnt <= '0; end
                RX_START: begin
                    if (tcnt == MID) begin
                        tcnt <= '0; bitn <= '0;
                        st   <= rxs ? RX_IDLE : RX_BITS;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_BITS: begin
                    if (tcnt == LAST) begin
                        tcnt <= '0;
                        if (bitn == STOPB) st <= rxs ? RX_IDLE : RX_BREAK;
                        else begin
                            sh   <= {rxs, sh[DW:1]};
                            bitn <= bitn + 1'b1;
                        end
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_BREAK: if (rxs) st <= RX_IDLE;
                default:  st <= RX_IDLE;
            endcase
        end
    end

    assign frame_done = en && tick && (st == RX_BITS) && (tcnt == LAST) && (bitn == STOPB);
    assign frame_data = sh[DW-1:0];
    assign frame_mpb  = sh[DW];

    // Receive buffer and status flags; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdrf <= 1'b0; oer <= 1'b0; fer <= 1'b0; data_q <= '0; is_id <= 1'b0;
        end else begin
            if (rd_ack)  rdrf <= 1'b0;
            if (err_clr) begin oer <= 1'b0; fer <= 1'b0; end
            if (frame_done && accept) begin
                if (!rxs)      fer <= 1'b1;
                else if (rdrf) oer <= 1'b1;
                else begin
                    data_q <= frame_data;
                    is_id  <= frame_mpb;
                    rdrf   <= 1'b1;
                end
            end
        end
    end

    a_r9_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oer) |-> $stable(data_q));
    a_r8_framing_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fer) |-> $stable(data_q));
endmodule

// File: rtl/mp_uart_filter.sv
// Address filter: keeps a skip state that address frames update; decides
// whether a completed frame is passed to the receive buffer.
// Assumes station_id is static while frames arrive.
module mp_uart_filter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic          frame_mpb,
    input  logic [DW-1:0] frame_data,
    input  logic [DW-1:0] station_id,
    output logic          accept
);
    logic skip;
    logic match;

    assign match  = (frame_data == station_id);
    assign accept = frame_mpb ? match : !skip;

    // Skip state: closed after reset, reopened only by a matching address.
    always_ff @(posedge clk) begin
        if (!rst_n)                      skip <= 1'b1;
        else if (frame_done && frame_mpb) skip <= !match;
    end
endmodule

// File: rtl/mp_uart.sv
// Top: addressed serial transceiver built from transmitter, receiver and
// address filter. Assumes tick runs at 16x the bit rate.
module mp_uart #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_byte,
    input  logic          tx_mpb,
    input  logic [DW-1:0] station_id,
    input  logic          rd_ack,
    input  logic          err_clr,
    input  logic          rxd,
    output logic          txd,
    output logic          tdre,
    output logic          tend,
    output logic          rdrf,
    output logic          oer,
    output logic          fer,
    output logic          perr,
    output logic [DW-1:0] rx_data,
    output logic          rx_is_id
);
    logic          f_done;
    logic          f_mpb;
    logic [DW-1:0] f_data;
    logic          f_accept;

    mp_uart_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en), .wr(tx_wr),
        .wdata(tx_byte), .wmpb(tx_mpb), .txd(txd), .tdre(tdre), .tend(tend)
    );

    mp_uart_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .rxd(rxd),
        .rd_ack(rd_ack), .err_clr(err_clr), .accept(f_accept),
        .frame_done(f_done), .frame_mpb(f_mpb), .frame_data(f_data),
        .rdrf(rdrf), .oer(oer), .fer(fer), .data_q(rx_data), .is_id(rx_is_id)
    );

    mp_uart_filter #(.DW(DW)) u_filt (
        .clk(clk), .rst_n(rst_n), .frame_done(f_done), .frame_mpb(f_mpb),
        .frame_data(f_data), .station_id(station_id), .accept(f_accept)
    );

    // No parity bit exists in this frame format.
    assign perr = 1'b0;

    a_r5_id_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdrf) && rx_is_id && $stable(station_id)) |-> (rx_data == station_id));
endmodule

// File: tb/sim_mp_uart.sv
`timescale 1ns/1ps
module sim_mp_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       tick;
    logic       tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, tx_mpb = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] station_id = 8'h3C;
    logic       rd_ack = 1'b0, err_clr = 1'b0, rxd = 1'b1;
    logic       txd, tdre, tend, rdrf, oer, fer, perr, rx_is_id;
    logic [7:0] rx_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd0);

    mp_uart u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .rx_en(rx_en),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_mpb(tx_mpb), .station_id(station_id),
        .rd_ack(rd_ack), .err_clr(err_clr), .rxd(rxd), .txd(txd), .tdre(tdre),
        .tend(tend), .rdrf(rdrf), .oer(oer), .fer(fer), .perr(perr),
        .rx_data(rx_data), .rx_is_id(rx_is_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bit is 16 ticks of 4 clocks each = 64 clocks.
    task automatic drive_frame(input logic [7:0] d, input logic m, input logic s);
        logic [10:0] f;
        f = {s, m, d, 1'b0};
        for (int k = 0; k < 11; k++) begin
            @(negedge clk) rxd = f[k];
            repeat (63) @(negedge clk);
        end
        @(negedge clk) rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic clr_err();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] d, input logic m);
        @(negedge clk) begin tx_wr = 1'b1; tx_byte = d; tx_mpb = m; end
        @(negedge clk) tx_wr = 1'b0;
        chk("R2 tdre after write", int'(tdre), 0);
        chk("R2 tend after write", int'(tend), 0);
    endtask

    task automatic tx_expect(input logic [7:0] d, input logic m);
        logic [10:0] f;
        int guard;
        f = {1'b1, m, d, 1'b0};
        guard = 0;
        while (txd && guard < 3000) begin @(negedge clk); guard++; end
        repeat (32) @(negedge clk);
        for (int k = 0; k < 11; k++) begin
            chk($sformatf("R1 tx bit %0d of %0h", k, d), int'(txd), int'(f[k]));
            repeat (64) @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle line", int'(txd), 1);
        chk("R2 reset tdre", int'(tdre), 1);
        chk("R2 reset tend", int'(tend), 1);
        chk("R10 reset rdrf", int'(rdrf), 0);
        chk("R10 reset oer", int'(oer), 0);
        chk("R10 reset fer", int'(fer), 0);

        // R3: disabled transmitter holds the byte.
        tx_write(8'h96, 1'b1);
        repeat (300) @(negedge clk);
        chk("R3 line idle while disabled", int'(txd), 1);
        chk("R3 byte still buffered", int'(tdre), 0);
        tx_en = 1'b1;
        tx_expect(8'h96, 1'b1);
        repeat (40) @(negedge clk);
        chk("R2 tend after frame", int'(tend), 1);

        // R1/R2 sweep of transmit patterns.
        for (int i = 0; i < 8; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 5);
            tx_write(d, i[0]);
            repeat (3) @(negedge clk);
            chk("R2 tdre after load", int'(tdre), 1);
            chk("R2 tend during frame", int'(tend), 0);
            tx_expect(d, i[0]);
            repeat (40) @(negedge clk);
            chk("R2 tend at end", int'(tend), 1);
        end

        // R7: payload before any address is dropped.
        rx_en = 1'b1;
        drive_frame(8'h55, 1'b0, 1'b1);
        chk("R7 dropped after reset", int'(rdrf), 0);

        // R5/R6/R7 address sweep, each followed by a payload frame.
        for (int i = 0; i < 16; i++) begin
            logic [7:0] id;
            logic [7:0] d;
            id = {i[3:0], 4'hC};
            d  = 8'(i * 17) ^ 8'h0F;
            drive_frame(id, 1'b1, 1'b1);
            if (id == station_id) begin
                chk("R5 id rdrf", int'(rdrf), 1);
                chk("R5 id flag", int'(rx_is_id), 1);
                chk("R5 id data", int'(rx_data), int'(id));
                ack();
            end else begin
                chk("R7 mismatched id not delivered", int'(rdrf), 0);
            end
            drive_frame(d, 1'b0, 1'b1);
            if (id == station_id) begin
                chk("R6 data rdrf", int'(rdrf), 1);
                chk("R6 data flag", int'(rx_is_id), 0);
                chk("R6 data value", int'(rx_data), int'(d));
                ack();
            end else begin
                chk("R7 skipped rdrf", int'(rdrf), 0);
                chk("R7 skipped oer", int'(oer), 0);
                chk("R7 skipped fer", int'(fer), 0);
            end
        end

        // Reopen, then R9 overrun.
        drive_frame(8'h3C, 1'b1, 1'b1);
        ack();
        drive_frame(8'h11, 1'b0, 1'b1);
        drive_frame(8'h22, 1'b0, 1'b1);
        chk("R9 oer set", int'(oer), 1);
        chk("R9 data kept", int'(rx_data), 8'h11);
        chk("R9 rdrf still set", int'(rdrf), 1);
        clr_err();
        ack();
        chk("R10 oer cleared", int'(oer), 0);
        chk("R10 rdrf cleared", int'(rdrf), 0);

        // R8 framing error.
        drive_frame(8'h33, 1'b0, 1'b0);
        chk("R8 fer set", int'(fer), 1);
        chk("R8 no delivery", int'(rdrf), 0);
        clr_err();
        chk("R10 fer cleared", int'(fer), 0);
        drive_frame(8'h44, 1'b0, 1'b1);
        chk("R8 recovery rdrf", int'(rdrf), 1);
        chk("R8 recovery data", int'(rx_data), 8'h44);
        ack();

        // R4 glitch rejection: a short low pulse must not disturb the filter.
        @(negedge clk) rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (800) @(negedge clk);
        chk("R4 glitch no rdrf", int'(rdrf), 0);
        chk("R4 glitch no fer", int'(fer), 0);
        drive_frame(8'h5A, 1'b0, 1'b1);
        chk("R4 next frame rdrf", int'(rdrf), 1);
        chk("R4 next frame data", int'(rx_data), 8'h5A);
        ack();

        // R11 disabled receiver.
        rx_en = 1'b0;
        drive_frame(8'h66, 1'b0, 1'b1);
        chk("R11 ignored while disabled", int'(rdrf), 0);
        rx_en = 1'b1;
        repeat (10) @(negedge clk);
        drive_frame(8'h77, 1'b0, 1'b1);
        chk("R11 data after enable", int'(rx_data), 8'h77);
        ack();
        chk("R10 perr stays 0", int'(perr), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule